// File: doc/BRIEF.md
# Banked Level-Interrupt Controller

This block gathers level-sensitive interrupt sources for a single processor. The sources are split into a parameterised number of identical banks of 32 inputs each. Every bank latches its active inputs into a pending register. Software clears pending bits with write-one-to-clear. An enable register selects which pending bits may raise that bank's request line to the processor.

Software reaches all banks over a plain register bus. The bus has a byte address, write data, a write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe. The banks sit one after another at a fixed stride of 0x28 bytes. For each bank the block also reports the index of the most significant pending and enabled source. Software is meant to service that source and trust no other bit of the bank's gated status.

Top module: `icu_top`

## Requirements
- R1: After a synchronous reset, every register of every bank reads zero. All request lines are low and all reported indexes are 0.
- R2: Bank n occupies byte addresses n*0x28 up to n*0x28+0x27. Within a bank, the registers sit at these offsets: pending 0x00, enable 0x08, gated status 0x10, resend 0x18 and mask 0x20. A read strobe in cycle k puts the addressed register's value on the read data port after the clock edge ending cycle k. In any cycle without a read strobe, the read data is zero.
- R3: A source input that is high when a clock edge arrives sets its pending bit at that edge. This takes priority over a write-one-to-clear of the same bit at the same edge.
- R4: Writing the pending register clears each bit written as 1. Bits written as 0 keep their value.
- R5: The enable and mask registers hold whatever was last written and change only on a write to them. The mask register has no effect on requests or indexes.
- R6: The gated-status register reads as pending AND enable. Writes to it are ignored.
- R7: A bank's request output is high one cycle after that bank's gated status is nonzero. It is low one cycle after the gated status is zero.
- R8: A bank's index output is the position (0 to 31) of the most significant set bit of the gated status, registered the same way as the request. It is 0 when the gated status is zero.
- R9: Writing the resend register sets the written bits in the resend register. At the next edge those bits become pending, and the resend register returns to zero.
- R10: Reads of offsets inside a bank that hold no register, and reads of addresses beyond the last bank, return zero. Writes there change nothing.
- R11: A write to one bank leaves every other bank's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_MOD*32 | Level interrupt sources; bank n uses bits n*32 to n*32+31 |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | NUM_MOD | Per-bank request line |
| irq_idx_o | output | NUM_MOD*5 | Per-bank most significant active source index |

## Verification
The main function is tried with random source pulses against random enable words and random clear words, spread over random banks. This separates errors in the gating of the gated status, in clear-on-one and in the most-significant-bit pick. Directed patterns follow. One enables both bit 31 and bit 0, then only bit 0, which exposes an inverted or lowest-first priority encoder. One drives a source and clears it in the same cycle, which tells apart the two possible orders of set and clear. Further directed writes go to the resend register, to the gated status, to holes in a bank, past the last bank and to a neighbouring bank, which shows whether decoding ever touches the wrong register.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned SRC_N   = 32;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned STRIDE  = 40;
  localparam logic [31:0] OFF_PEND = 32'h00;
  localparam logic [31:0] OFF_EN   = 32'h08;
  localparam logic [31:0] OFF_GATE = 32'h10;
  localparam logic [31:0] OFF_RSND = 32'h18;
  localparam logic [31:0] OFF_MASK = 32'h20;
endpackage

// File: rtl/icu_msb.sv
module icu_msb
  import icu_pkg::*;
(
  input  logic [SRC_N-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < int'(SRC_N); i++) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/icu_bank.sv
module icu_bank
  import icu_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_N-1:0]  src,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              wr,
  output logic [31:0]       rd_val,
  output logic [SRC_N-1:0]  pend,
  output logic [SRC_N-1:0]  en,
  output logic [SRC_N-1:0]  rsnd,
  output logic [SRC_N-1:0]  gate
);
  localparam logic [31:0] LO = 32'(BASE);
  localparam logic [31:0] HI = 32'(BASE + STRIDE);

  logic [31:0]      a32, off;
  logic             hit;
  logic             wr_pend, wr_en, wr_rsnd, wr_mask;
  logic [SRC_N-1:0] mask;

  assign a32  = 32'(addr);
  assign off  = a32 - LO;
  assign hit  = (a32 >= LO) && (a32 < HI);
  assign gate = pend & en;

  assign wr_pend = wr && hit && (off == OFF_PEND);
  assign wr_en   = wr && hit && (off == OFF_EN);
  assign wr_rsnd = wr && hit && (off == OFF_RSND);
  assign wr_mask = wr && hit && (off == OFF_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      en   <= '0;
      rsnd <= '0;
      mask <= '0;
    end else begin
      // sources and resend win over a same-cycle clear
      pend <= (pend & ~(wr_pend ? wdata : '0)) | src | rsnd;
      rsnd <= wr_rsnd ? wdata : '0;
      if (wr_en)   en   <= wdata;
      if (wr_mask) mask <= wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit) begin
      case (off)
        OFF_PEND: rd_val = pend;
        OFF_EN:   rd_val = en;
        OFF_GATE: rd_val = gate;
        OFF_RSND: rd_val = rsnd;
        OFF_MASK: rd_val = mask;
        default:  rd_val = '0;
      endcase
    end
  end
endmodule

// File: rtl/icu_top.sv
module icu_top
  import icu_pkg::*;
#(
  parameter int unsigned NUM_MOD = 5,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_MOD*SRC_N-1:0] src_i,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  output logic [31:0]              bus_rdata,
  output logic [NUM_MOD-1:0]       irq_o,
  output logic [NUM_MOD*IDX_W-1:0] irq_idx_o
);
  logic [NUM_MOD-1:0][31:0]      rv_a;
  logic [NUM_MOD-1:0][SRC_N-1:0] st_a, en_a, rs_a, gt_a;
  logic [NUM_MOD-1:0][IDX_W-1:0] idx_a;
  logic [NUM_MOD-1:0]            any_a;
  logic [31:0]                   rd_or;

  for (genvar m = 0; m < int'(NUM_MOD); m++) begin : g_bank
    icu_bank #(.ADDR_W(ADDR_W), .BASE(m * STRIDE)) u_bank (
      .clk(clk), .rst(rst),
      .src(src_i[m*SRC_N +: SRC_N]),
      .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr),
      .rd_val(rv_a[m]), .pend(st_a[m]), .en(en_a[m]),
      .rsnd(rs_a[m]), .gate(gt_a[m])
    );
    icu_msb u_msb (.vec(gt_a[m]), .idx(idx_a[m]), .any(any_a[m]));
  end

  always_comb begin
    rd_or = '0;
    for (int m = 0; m < int'(NUM_MOD); m++) rd_or = rd_or | rv_a[m];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= '0;
      irq_idx_o <= '0;
    end else begin
      bus_rdata <= bus_rd ? rd_or : '0;
      irq_o     <= any_a;
      for (int m = 0; m < int'(NUM_MOD); m++)
        irq_idx_o[m*IDX_W +: IDX_W] <= idx_a[m];
    end
  end
endmodule

// File: rtl/icu_top_chk.sv
module icu_top_chk
  import icu_pkg::*;
#(
  parameter int unsigned NUM_MOD = 5
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NUM_MOD*SRC_N-1:0]      src_i,
  input logic                          bus_wr,
  input logic [NUM_MOD-1:0]            irq_o,
  input logic [NUM_MOD*IDX_W-1:0]      irq_idx_o,
  input logic [NUM_MOD-1:0][SRC_N-1:0] st_a,
  input logic [NUM_MOD-1:0][SRC_N-1:0] en_a,
  input logic [NUM_MOD-1:0][SRC_N-1:0] rs_a
);
  for (genvar m = 0; m < int'(NUM_MOD); m++) begin : g_chk
    // R7
    irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
      irq_o[m] == $past(|(st_a[m] & en_a[m])));
    // R8
    idx_is_msb_chk: assert property (@(posedge clk) disable iff (rst)
      irq_o[m] |-> (($past(st_a[m] & en_a[m]) >> irq_idx_o[m*IDX_W +: IDX_W]) == 32'd1));
    // R3
    src_latched_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ((st_a[m] & $past(src_i[m*SRC_N +: SRC_N])) == $past(src_i[m*SRC_N +: SRC_N])));
    // R9
    resend_sets_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ((st_a[m] & $past(rs_a[m])) == $past(rs_a[m])));
    // R9
    resend_clears_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(bus_wr) |-> (rs_a[m] == '0));
    // R5
    enable_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(bus_wr) && !$past(rst)) |-> $stable(en_a[m]));
  end
endmodule

bind icu_top icu_top_chk #(.NUM_MOD(NUM_MOD)) u_chk (
  .clk(clk), .rst(rst), .src_i(src_i), .bus_wr(bus_wr),
  .irq_o(irq_o), .irq_idx_o(irq_idx_o),
  .st_a(st_a), .en_a(en_a), .rs_a(rs_a)
);

// File: tb/test_icu_top.sv
module test_icu_top;
  localparam int NM = 5;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NM*32-1:0] src = '0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic            wr = 1'b0, rd = 1'b0;
  logic [31:0]     rdata;
  logic [NM-1:0]   irq;
  logic [NM*5-1:0] idx;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [31:0] e_st [NM];
  logic [31:0] e_en [NM];
  logic [31:0] e_mk [NM];

  always #2.5 clk = ~clk;

  icu_top #(.NUM_MOD(NM), .ADDR_W(AW)) i_icu_top (
    .clk(clk), .rst(rst), .src_i(src), .bus_addr(addr), .bus_wdata(wdata),
    .bus_wr(wr), .bus_rd(rd), .bus_rdata(rdata), .irq_o(irq), .irq_idx_o(idx)
  );

  function automatic logic [31:0] msb_of(logic [31:0] v);
    msb_of = 0;
    for (int i = 0; i < 32; i++) if (v[i]) msb_of = i;
  endfunction

  function automatic logic [AW-1:0] ad(int m, int off);
    ad = AW'(m * 40 + off);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic pulse(int m, logic [31:0] p);
    @(negedge clk); src[m*32 +: 32] = p;
    @(negedge clk); src[m*32 +: 32] = '0;
  endtask

  task automatic check_out(string r7, string r8, int m);
    @(negedge clk); @(negedge clk);
    check(r7, 32'(irq[m]), 32'(|(e_st[m] & e_en[m])));
    check(r8, 32'(idx[m*5 +: 5]), msb_of(e_st[m] & e_en[m]));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, p, e, c;
    int m;
    void'($urandom(32'd1234));
    for (int i = 0; i < NM; i++) begin e_st[i] = 0; e_en[i] = 0; e_mk[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 idx", 32'(idx), 0);
    for (int k = 0; k < NM; k++)
      for (int o = 0; o <= 32; o += 8) begin
        bus_read(ad(k, o), v); check("R1 reg", v, 0);
      end
    // R2 no read strobe gives zero read data
    @(negedge clk); check("R2 idle rdata", rdata, 0);

    // random main function R3 R4 R6 R7 R8
    for (int it = 0; it < 40; it++) begin
      m = int'($urandom % NM);
      p = $urandom; e = $urandom; c = $urandom;
      pulse(m, p); e_st[m] |= p;
      bus_write(ad(m, 8), e); e_en[m] = e;
      bus_read(ad(m, 16), v); check("R6 gated", v, e_st[m] & e_en[m]);
      bus_read(ad(m, 0), v);  check("R3 pending", v, e_st[m]);
      check_out("R7 request", "R8 index", m);
      bus_write(ad(m, 0), c); e_st[m] &= ~c;
      bus_read(ad(m, 0), v);  check("R4 w1c", v, e_st[m]);
    end

    // clear everything
    for (int k = 0; k < NM; k++) begin
      bus_write(ad(k, 0), 32'hFFFF_FFFF); e_st[k] = 0;
    end
    check_out("R7 request low", "R8 index zero", 2);

    // R8 directed priority
    pulse(1, 32'h8000_0001); e_st[1] = 32'h8000_0001;
    bus_write(ad(1, 8), 32'hFFFF_FFFF); e_en[1] = 32'hFFFF_FFFF;
    check_out("R7 both", "R8 msb31", 1);
    bus_write(ad(1, 8), 32'h0000_0001); e_en[1] = 32'h1;
    check_out("R7 low only", "R8 bit0", 1);

    // R3 set wins over same-cycle clear
    @(negedge clk); src[3*32 +: 32] = 32'h10; addr = ad(3, 0); wdata = 32'h10; wr = 1'b1;
    @(negedge clk); src[3*32 +: 32] = '0; wr = 1'b0; e_st[3] |= 32'h10;
    bus_read(ad(3, 0), v); check("R3 set beats clear", v, e_st[3]);

    // R9 resend
    bus_write(ad(4, 24), 32'h0F00_0A00);
    bus_read(ad(4, 24), v); check("R9 resend self-clears", v, 0);
    e_st[4] |= 32'h0F00_0A00;
    bus_read(ad(4, 0), v); check("R9 resend sets pending", v, e_st[4]);

    // R5 mask storage and no effect
    bus_write(ad(1, 32), 32'hFFFF_FFFF); e_mk[1] = 32'hFFFF_FFFF;
    bus_read(ad(1, 32), v); check("R5 mask", v, e_mk[1]);
    check_out("R5 request ignores mask", "R5 index ignores mask", 1);
    bus_read(ad(1, 8), v); check("R5 enable held", v, e_en[1]);

    // R6 write to gated status ignored
    bus_write(ad(1, 16), 32'h0);
    bus_read(ad(1, 16), v); check("R6 gated write ignored", v, e_st[1] & e_en[1]);
    bus_read(ad(1, 0), v);  check("R6 pending untouched", v, e_st[1]);

    // R10 holes and beyond last bank
    bus_write(ad(0, 4), 32'hDEAD_BEEF);
    bus_read(ad(0, 4), v); check("R10 hole read", v, 0);
    bus_read(ad(0, 0), v); check("R10 pending unchanged", v, e_st[0]);
    bus_read(ad(0, 8), v); check("R10 enable unchanged", v, e_en[0]);
    bus_read(ad(0, 32), v); check("R10 mask unchanged", v, e_mk[0]);
    bus_write(AW'(NM * 40), 32'h1234_5678);
    bus_read(AW'(NM * 40), v); check("R10 past last bank", v, 0);

    // R11 bank isolation
    bus_write(ad(3, 8), 32'hA5A5_A5A5); e_en[3] = 32'hA5A5_A5A5;
    bus_read(ad(2, 8), v); check("R11 neighbour enable", v, e_en[2]);
    bus_read(ad(4, 8), v); check("R11 other neighbour", v, e_en[4]);
    bus_read(ad(3, 8), v); check("R2 bank3 enable", v, e_en[3]);

    finish_run();
  end
endmodule